// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Sequencer

This block sits between a synchronous requester and an external asynchronous static RAM of 32K words by 8 bits. It takes one read or write request at a time over a valid/acknowledge handshake. It turns each request into a timed cycle on the memory pins: a 15-bit address, an 8-bit data path split into output value, output enable and input value, and three active-low strobes (select, write, output enable). The address-setup, strobe, data turn-off, data-setup, data-hold, recovery and read-access intervals are parameters given in clock cycles.

Each write names one of two termination styles. In the write-terminated style, the select strobe is low for the whole cycle and the write strobe opens and closes the write window. In the select-terminated style, the write strobe falls first and the select strobe opens and closes the window. A write-terminated request may also ask for the memory's output enable to stay low during the cycle. In that case the write pulse is stretched to cover the memory's driver turn-off plus the data setup. The controller drives the data pins only once the memory has released them.

The state machine has six states. IDLE waits for a request. SETUP holds the address ahead of the strobe. PULSE is the write window. RECOV covers data hold and write recovery. ACCESS is the read strobe. DONE raises acknowledge. The transitions are:
- IDLE→SETUP on a request.
- SETUP→PULSE for a write, or SETUP→ACCESS for a read, after TAS cycles.
- PULSE→RECOV after the pulse count.
- RECOV→DONE after TWR cycles.
- ACCESS→DONE after TRD cycles.
- DONE→IDLE always.

Top module: `asram_seq`

## Requirements
- R1: While reset is asserted and right after it, all three strobes are high, the data-pin output enable is low and acknowledge is low.
- R2: The address pins change only while the select strobe or the write strobe is high, never while both are low.
- R3: A write-terminated write with output enable high (req_style=0, req_oe_hold=0) holds the write strobe low for TWP cycles and the select strobe low for TAS+TWP+TWR cycles. Acknowledge comes TAS+TWP+TWR+1 cycles after acceptance.
- R4: A write-terminated write with req_oe_hold=1 keeps the output enable low through SETUP and PULSE. The write strobe is low for max(TWP, TWHZ+TDW) cycles. The data pins are driven only from TWHZ cycles after the write strobe falls, so nothing contends with the memory's drivers.
- R5: A select-terminated write (req_style=1) lowers the write strobe TAS cycles before the select strobe. It holds the select strobe low for TWP cycles and raises the select strobe before the write strobe. The output enable stays high, and the data pins may be driven from the start of the cycle.
- R6: Write data is driven and unchanged for at least TDW cycles before the end of the write window, and is held for TDH cycles after it. The data is committed at the address that was presented.
- R7: A read drops the select strobe at SETUP and the output enable for TRD cycles, with the data pins never driven. It returns the value sampled in the last access cycle on rsp_rdata, together with acknowledge, TAS+TRD+1 cycles after acceptance.
- R8: Acknowledge lasts exactly one cycle. A request is taken only in IDLE, and its fields are latched then, so changes to the fields during the cycle have no effect.
- R9: A read returns the byte most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present; hold until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_style | input | 1 | Write termination: 0 = write strobe ends, 1 = select strobe ends |
| req_oe_hold | input | 1 | Keep memory output enable low during a write-terminated write |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with acknowledge |
| mem_addr | output | 15 | Memory address pins |
| mem_dq_out | output | 8 | Value for the data pins |
| mem_dq_oe | output | 1 | Controller drives the data pins when high |
| mem_dq_in | input | 8 | Value seen on the data pins |
| mem_cs_n | output | 1 | Select strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |

## Verification
The hardest situation to reach is the stretched write. In that cycle the memory is still driving the data pins after the write strobe falls, so an early controller driver would contend and a short pulse would violate data setup. Seeing either fault needs a memory model that tracks the turn-off window cycle by cycle. The bench's behavioral memory does this. It also flags address motion inside the strobe overlap and checks setup and hold. Directed writes in all three write variants at both ends of the address range are mixed with seeded random operations over a small address pool, so that reads land on freshly written words.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_PULSE  = 3'd2,
        ST_RECOV  = 3'd3,
        ST_ACCESS = 3'd4,
        ST_DONE   = 3'd5
    } seq_state_t;

    typedef enum logic {
        WS_WE_END = 1'b0,
        WS_CS_END = 1'b1
    } wr_style_t;

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/asram_strobe_gen.sv
module asram_strobe_gen
    import asram_pkg::*;
#(
    parameter int CW   = 4,
    parameter int TWHZ = 2,
    parameter int TDH  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_state_t    state,
    input  logic [CW-1:0] cnt,
    input  logic          is_write,
    input  wr_style_t     style,
    input  logic          oe_hold,
    output logic          cs_n,
    output logic          we_n,
    output logic          oe_n,
    output logic          dq_oe
);
    localparam logic [CW-1:0] L_TWHZ = CW'(TWHZ);
    localparam logic [CW-1:0] L_TDH  = CW'(TDH);

    logic we_style;
    assign we_style = (style == WS_WE_END);

    always_comb begin
        cs_n  = 1'b1;
        we_n  = 1'b1;
        oe_n  = 1'b1;
        dq_oe = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE: begin
            end
            ST_SETUP: begin
                if (!is_write) begin
                    cs_n = 1'b0;
                end else if (we_style) begin
                    cs_n  = 1'b0;
                    oe_n  = !oe_hold;
                    dq_oe = !oe_hold;
                end else begin
                    we_n  = 1'b0;
                    dq_oe = 1'b1;
                end
            end
            ST_PULSE: begin
                cs_n = 1'b0;
                we_n = 1'b0;
                if (we_style) begin
                    oe_n  = !oe_hold;
                    dq_oe = !oe_hold || (cnt >= L_TWHZ);
                end else begin
                    dq_oe = 1'b1;
                end
            end
            ST_RECOV: begin
                if (we_style) cs_n = 1'b0;
                else          we_n = 1'b0;
                dq_oe = (cnt < L_TDH);
            end
            ST_ACCESS: begin
                cs_n = 1'b0;
                oe_n = 1'b0;
            end
            default: begin
            end
        endcase
    end

    // R7: the controller never drives while the memory output enable is low with write high
    p_read_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && we_n) |-> !dq_oe);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int TAS  = 1,
    parameter int TWP  = 2,
    parameter int TWHZ = 2,
    parameter int TDW  = 2,
    parameter int TDH  = 1,
    parameter int TWR  = 2,
    parameter int TRD  = 3,
    parameter int AW   = 15,
    parameter int DW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_style,
    input  logic          req_oe_hold,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ack,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          mem_oe_n
);
    localparam int PW_OE = (TWP > TWHZ + TDW) ? TWP : (TWHZ + TDW);
    localparam int M1    = (TAS > PW_OE) ? TAS : PW_OE;
    localparam int M2    = (TWR > TRD) ? TWR : TRD;
    localparam int MAXC  = (M1 > M2) ? M1 : M2;
    localparam int CW    = $clog2(MAXC + 1);

    localparam logic [CW-1:0] L_TAS   = CW'(TAS - 1);
    localparam logic [CW-1:0] L_TWP   = CW'(TWP - 1);
    localparam logic [CW-1:0] L_PW_OE = CW'(PW_OE - 1);
    localparam logic [CW-1:0] L_TWR   = CW'(TWR - 1);
    localparam logic [CW-1:0] L_TRD   = CW'(TRD - 1);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt;
    logic          wr_q, oeh_q;
    wr_style_t     style_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic [CW-1:0] pulse_last;

    assign pulse_last = (style_q == WS_WE_END && oeh_q) ? L_PW_OE : L_TWP;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_SETUP;
            ST_SETUP:  if (cnt == L_TAS) state_d = wr_q ? ST_PULSE : ST_ACCESS;
            ST_PULSE:  if (cnt == pulse_last) state_d = ST_RECOV;
            ST_RECOV:  if (cnt == L_TWR) state_d = ST_DONE;
            ST_ACCESS: if (cnt == L_TRD) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            oeh_q   <= 1'b0;
            style_q <= WS_WE_END;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                wr_q    <= req_write;
                oeh_q   <= req_oe_hold;
                style_q <= wr_style_t'(req_style);
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_ACCESS && cnt == L_TRD) begin
                rdata_q <= mem_dq_in;
            end
        end
    end

    asram_phase_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_d != state_q),
        .cnt   (cnt)
    );

    asram_strobe_gen #(.CW(CW), .TWHZ(TWHZ), .TDH(TDH)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state_q),
        .cnt      (cnt),
        .is_write (wr_q),
        .style    (style_q),
        .oe_hold  (oeh_q),
        .cs_n     (mem_cs_n),
        .we_n     (mem_we_n),
        .oe_n     (mem_oe_n),
        .dq_oe    (mem_dq_oe)
    );

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_rdata  = rdata_q;
    assign req_ack    = (state_q == ST_DONE);

    // R2: address frozen inside the strobe overlap
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !mem_we_n) |=> ((!mem_cs_n && !mem_we_n) -> $stable(mem_addr)));

    // R8: acknowledge is a single-cycle pulse
    p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    // R5: in select-terminated writes the select strobe rises while write is still low
    p_cs_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (style_q == WS_CS_END && wr_q && $rose(mem_cs_n)) |-> !mem_we_n);

    // R6: data stays driven in the cycle after the write window closes
    generate
        if (TDH > 0) begin : g_hold_chk
            p_hold_after_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(!mem_cs_n && !mem_we_n) && !(!mem_cs_n && !mem_we_n))
                |-> (mem_dq_oe && $stable(mem_dq_out)));
        end
    endgenerate

endmodule

// File: tb/asram_seq_bench.sv
module asram_seq_bench;
    localparam int TAS = 1, TWP = 2, TWHZ = 2, TDW = 2, TDH = 1, TWR = 2, TRD = 3;
    localparam int PW_OE = (TWP > TWHZ + TDW) ? TWP : (TWHZ + TDW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_style = 1'b0, req_oe_hold = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ack;
    logic [7:0]  rsp_rdata;
    logic [14:0] mem_addr;
    logic [7:0]  mem_dq_out, mem_dq_in;
    logic        mem_dq_oe, mem_cs_n, mem_we_n, mem_oe_n;

    int n_tests = 0, n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    asram_seq u_asram_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_style(req_style), .req_oe_hold(req_oe_hold), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ack(req_ack), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
    );

    // ---------------- behavioral memory ----------------
    logic [7:0] marr [int];
    logic [7:0] shadow [int];
    int viol_addr = 0, viol_setup = 0, viol_hold = 0, viol_cont = 0;
    logic prev_ov = 1'b0, prev_we = 1'b1, wsel = 1'b0;
    int   wl = 0, ds = 0, ds_prev = 0, hold_left = 0;
    logic [14:0] prev_addr = '0;
    logic [7:0]  prev_dq = '0, held = '0;
    logic        prev_dqoe = 1'b0;
    logic [7:0]  rd_q = '0;
    logic        drive;

    function automatic logic [7:0] init_val(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]};
    endfunction

    function automatic logic [7:0] mem_rd(input logic [14:0] a);
        if (marr.exists(int'(a))) return marr[int'(a)];
        return init_val(a);
    endfunction

    assign mem_dq_in = rd_q;

    always @(negedge clk) begin
        logic ov;
        ov = !mem_cs_n && !mem_we_n;
        if (!mem_we_n) begin
            if (prev_we) begin wl = 0; wsel = !mem_cs_n; end
            else wl++;
        end
        drive = !mem_cs_n && !mem_oe_n && (mem_we_n || (wsel && wl < TWHZ));
        if (drive && mem_dq_oe) viol_cont++;
        if (ov && prev_ov && mem_addr != prev_addr) viol_addr++;
        if (mem_dq_oe && prev_dqoe && mem_dq_out == prev_dq) ds++;
        else ds = mem_dq_oe ? 1 : 0;
        if (hold_left > 0) begin
            if (!mem_dq_oe || mem_dq_out != held) viol_hold++;
            hold_left--;
        end
        if (prev_ov && !ov) begin
            if (ds_prev < TDW) viol_setup++;
            marr[int'(prev_addr)] = prev_dq;
            held = prev_dq;
            hold_left = TDH;
            if (hold_left > 0) begin
                if (!mem_dq_oe || mem_dq_out != held) viol_hold++;
                hold_left--;
            end
        end
        rd_q <= drive ? mem_rd(mem_addr) : 8'h00;
        prev_ov = ov; prev_we = mem_we_n; prev_addr = mem_addr;
        prev_dq = mem_dq_out; prev_dqoe = mem_dq_oe; ds_prev = ds;
    end

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_lat(input bit wr, input bit st, input bit oeh);
        if (!wr) return TAS + TRD + 1;
        if (st) return TAS + TWP + TWR + 1;
        return TAS + (oeh ? PW_OE : TWP) + TWR + 1;
    endfunction

    function automatic int exp_we(input bit wr, input bit st, input bit oeh);
        if (!wr) return 0;
        if (st) return TAS + TWP + TWR;
        return oeh ? PW_OE : TWP;
    endfunction

    function automatic int exp_cs(input bit wr, input bit st, input bit oeh);
        if (!wr) return TAS + TRD;
        if (st) return TWP;
        return TAS + (oeh ? PW_OE : TWP) + TWR;
    endfunction

    function automatic int exp_oe(input bit wr, input bit st, input bit oeh);
        if (!wr) return TRD;
        if (!st && oeh) return TAS + PW_OE;
        return 0;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [14:0] a);
        if (shadow.exists(int'(a))) return shadow[int'(a)];
        return init_val(a);
    endfunction

    task automatic do_op(input bit wr, input bit st, input bit oeh,
                         input logic [14:0] a, input logic [7:0] d, input bit perturb);
        int n = 0, wec = 0, csc = 0, oec = 0;
        @(negedge clk);
        req_write = wr; req_style = st; req_oe_hold = oeh;
        req_addr = a; req_wdata = d; req_valid = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (perturb && n == 1) begin
                req_addr = ~a; req_wdata = ~d; req_style = ~st; req_oe_hold = ~oeh;
            end
            wec += !mem_we_n; csc += !mem_cs_n; oec += !mem_oe_n;
        end while (!req_ack && n < 100);
        req_valid = 1'b0;
        check(n == exp_lat(wr, st, oeh), wr ? (st ? "R5 latency" : (oeh ? "R4 latency" : "R3 latency")) : "R7 latency",
              n, exp_lat(wr, st, oeh));
        check(wec == exp_we(wr, st, oeh), wr ? (st ? "R5 we_n low" : (oeh ? "R4 we_n low" : "R3 we_n low")) : "R7 we_n low",
              wec, exp_we(wr, st, oeh));
        check(csc == exp_cs(wr, st, oeh), wr ? (st ? "R5 cs_n low" : "R3 cs_n low") : "R7 cs_n low",
              csc, exp_cs(wr, st, oeh));
        check(oec == exp_oe(wr, st, oeh), wr ? "R4 oe_n low" : "R7 oe_n low", oec, exp_oe(wr, st, oeh));
        if (wr) shadow[int'(a)] = d;
        else check(rsp_rdata == exp_rd(a), "R9 read data", int'(rsp_rdata), int'(exp_rd(a)));
        @(negedge clk);
        check(!req_ack, "R8 ack single", int'(req_ack), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes in reset",
              int'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
        check(!mem_dq_oe && !req_ack, "R1 drive/ack in reset", int'({mem_dq_oe, req_ack}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ack, "R1 after reset",
              int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ack}), 28);

        // directed corners: every write variant at both ends of the address range
        do_op(1'b0, 1'b0, 1'b0, 15'h0000, 8'h00, 1'b0);
        do_op(1'b1, 1'b0, 1'b0, 15'h0000, 8'hA5, 1'b0);
        do_op(1'b1, 1'b0, 1'b1, 15'h7FFF, 8'h3C, 1'b0);
        do_op(1'b1, 1'b1, 1'b0, 15'h4001, 8'hFF, 1'b0);
        do_op(1'b0, 1'b0, 1'b0, 15'h0000, 8'h00, 1'b0);
        do_op(1'b0, 1'b1, 1'b1, 15'h7FFF, 8'h00, 1'b0);
        do_op(1'b0, 1'b0, 1'b0, 15'h4001, 8'h00, 1'b0);
        // R8: fields changed after acceptance must not matter
        do_op(1'b1, 1'b1, 1'b0, 15'h1234, 8'h5A, 1'b1);
        do_op(1'b1, 1'b0, 1'b1, 15'h2345, 8'hC3, 1'b1);
        do_op(1'b0, 1'b0, 1'b0, 15'h1234, 8'h00, 1'b1);
        do_op(1'b0, 1'b0, 1'b0, 15'h2345, 8'h00, 1'b0);
        check(rsp_rdata == 8'hC3, "R8 rdata held", int'(rsp_rdata), 8'hC3);

        // seeded random mix over a small address pool
        void'($urandom(32'd1357));
        for (int i = 0; i < 80; i++) begin
            logic [14:0] a;
            a = {($urandom % 2) ? 4'hF : 4'h0, 7'd0, 4'($urandom % 16)};
            do_op(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), a, 8'($urandom), 1'b0);
        end

        check(viol_addr == 0, "R2 address moved in overlap", viol_addr, 0);
        check(viol_setup == 0, "R6 data setup", viol_setup, 0);
        check(viol_hold == 0, "R6 data hold", viol_hold, 0);
        check(viol_cont == 0, "R4 bus contention", viol_cont, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule